// File: doc/BRIEF.md
# I2C Slave Register Access Engine

This block is the serial front end of a small register bank behind a two-wire bus. It samples the bus clock and data lines with the system clock and finds START and STOP conditions on the synchronised samples. It answers one fixed 7-bit device identifier (0101000) and accepts a single register address byte. The block takes part by pulling the data line low through an open-drain enable; it never drives the line high.

A write transaction delivers one data byte to the register bank as a single-cycle strobe carrying address and data. A read transaction uses a repeated START. The engine raises a read request carrying the stored address, then shifts the returned byte out MSB first. An active-low write-protect input refuses data bytes. A busy input from the non-volatile storage controller makes the engine ignore the bus entirely. A STOP that closes a committed write raises a one-cycle indication, so the storage controller can start a persistent update.

Top module: `i2cs_reg_engine`

## Requirements
- R1: After reset the data-line pull enable is off, and no write strobe, read request or stop indication is raised.
- R2: An identification byte whose upper seven bits are 0101000 is acknowledged (data line pulled low during the ninth clock). Its LSB selects the direction: 0 = write, 1 = read. Any other identification byte is not acknowledged, and the engine ignores the bus until the next START.
- R3: Register addresses 0, 1 and 2 are acknowledged. Any other address byte is not acknowledged, and the following data byte is ignored.
- R4: The data byte of a write to address 0 or 2 is received MSB first and appears on a one-cycle write strobe with that address. The strobe is raised 3 system clocks after the SCL falling edge that clocks in the data LSB, and the data byte is acknowledged.
- R5: A data byte written to address 1 is acknowledged but produces no write strobe.
- R6: While write-protect is low, a data byte is neither acknowledged nor strobed, and the engine waits for a new START. The register that was targeted keeps its value.
- R7: After an address byte, a repeated START and an identification byte with LSB 1 are acknowledged. The engine issues one read request with the stored address and shifts the returned byte out MSB first on the following eight clocks.
- R8: A read identification byte that does not follow an acknowledged address within the same transaction (since the last STOP) is not acknowledged.
- R9: A STOP ending a transaction in which a write strobe occurred raises the stop indication for exactly one cycle. A STOP after a read, or after a write to address 1, raises nothing.
- R10: A START or STOP in the middle of a byte aborts the transfer and restarts bit counting, so the next complete transaction is decoded correctly.
- R11: While the storage-busy input is high, the pull enable stays off, START is ignored and no strobe or request is raised.
- R12: Only one data byte per write transaction is accepted; a further byte before STOP is not acknowledged and not strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock sample |
| sda_i | input | 1 | Raw bus data sample (wired line level) |
| wp_n | input | 1 | Write protect, active low |
| nv_busy | input | 1 | Storage controller busy (recall or persistent write) |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Address for the write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_addr | output | 8 | Address of the register to be read |
| reg_rd_data | input | 8 | Read data; must be valid from the read request until the end of the ninth clock |
| stop_commit | output | 1 | One-cycle pulse on a STOP that closes a committed write |

## Verification
Every bus event passes through two synchroniser flops and is then registered by the controller. A strobe, request or change of the pull enable therefore appears 3 system clocks after the SCL or SDA edge that caused it. The bench holds every bus phase for 10 system clocks and samples the acknowledge and read bits in the middle of the SCL high phase, well after that 3-cycle window. It records the cycle of the data LSB's falling SCL edge and the cycle of the write strobe, and checks that they differ by exactly 3. Strobes are counted by a monitor running on the opposite clock edge, so single-cycle pulses are never missed.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RMACK
  } i2cs_state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              prev;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
          prev  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], raw[g]};
          prev  <= chain[STAGES-1];
        end
      end

      assign level[g] = chain[STAGES-1];
      assign rise[g]  = chain[STAGES-1] & ~prev;
      assign fall[g]  = ~chain[STAGES-1] & prev;
    end
  endgenerate

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic bus_start,
  output logic bus_stop
);

  // data may only move while the clock is low; a move while high is a condition
  assign bus_start = sda_fall & scl_lvl;
  assign bus_stop  = sda_rise & scl_lvl;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ID   = 7'b0101000,
  parameter int         REG_TOP  = 2,
  parameter int         RSV_ADDR = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        sda_lvl,
  input  logic        bus_start,
  input  logic        bus_stop,
  input  logic        wp_n,
  input  logic        nv_busy,
  input  logic [7:0]  rd_data,
  output logic        sda_pull,
  output logic        wr_stb,
  output logic [7:0]  wr_addr,
  output logic [7:0]  wr_data,
  output logic        rd_req,
  output logic [7:0]  rd_addr,
  output logic        stop_commit
);

  localparam logic [7:0]       TOP_B  = 8'(REG_TOP);
  localparam logic [7:0]       RSV_B  = 8'(RSV_ADDR);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(BYTE_W);

  i2cs_state_e      st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic [7:0]       addr_q, addr_n;
  logic [7:0]       wdat_q, wdat_n;
  logic             aok_q, aok_n;
  logic             rdm_q, rdm_n;
  logic             wrote_q, wrote_n;
  logic             oe_q, oe_n;
  logic             wstb_q, wstb_n;
  logic             rreq_q, rreq_n;
  logic             scmt_q, scmt_n;

  logic byte_full;
  logic id_ok;
  assign byte_full = (cnt_q == FULL_C);
  assign id_ok     = (sh_q[7:1] == DEV_ID) && (!sh_q[0] || aok_q);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    wdat_n  = wdat_q;
    aok_n   = aok_q;
    rdm_n   = rdm_q;
    wrote_n = wrote_q;
    oe_n    = oe_q;
    wstb_n  = 1'b0;
    rreq_n  = 1'b0;
    scmt_n  = 1'b0;
    if (nv_busy) begin
      st_n    = ST_IDLE;
      oe_n    = 1'b0;
      cnt_n   = '0;
      aok_n   = 1'b0;
      wrote_n = 1'b0;
    end else if (bus_stop) begin
      st_n    = ST_IDLE;
      oe_n    = 1'b0;
      cnt_n   = '0;
      aok_n   = 1'b0;
      wrote_n = 1'b0;
      scmt_n  = wrote_q;
    end else if (bus_start) begin
      st_n  = ST_ID;
      oe_n  = 1'b0;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_ID, ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_lvl};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt_n = '0;
            st_n  = ST_IDLE;
            if (st_q == ST_ID) begin
              if (id_ok) begin
                st_n   = ST_ID_ACK;
                oe_n   = 1'b1;
                rdm_n  = sh_q[0];
                rreq_n = sh_q[0];
              end
            end else if (st_q == ST_ADDR) begin
              if (sh_q <= TOP_B) begin
                st_n   = ST_ADDR_ACK;
                oe_n   = 1'b1;
                addr_n = sh_q;
              end
            end else if (wp_n) begin
              st_n = ST_WDATA_ACK;
              oe_n = 1'b1;
              if (addr_q != RSV_B) begin
                wstb_n  = 1'b1;
                wdat_n  = sh_q;
                wrote_n = 1'b1;
              end
            end
          end
        end
        ST_ID_ACK: begin
          if (scl_fall) begin
            if (rdm_q) begin
              st_n = ST_RDATA;
              sh_n = rd_data;
              oe_n = ~rd_data[7];
            end else begin
              st_n = ST_ADDR;
              oe_n = 1'b0;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            st_n  = ST_WDATA;
            oe_n  = 1'b0;
            aok_n = 1'b1;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            st_n = ST_IDLE;
            oe_n = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              st_n  = ST_RMACK;
              oe_n  = 1'b0;
              cnt_n = '0;
            end else begin
              sh_n = {sh_q[6:0], 1'b0};
              oe_n = ~sh_q[6];
            end
          end
        end
        ST_RMACK: begin
          if (scl_fall) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      aok_q   <= 1'b0;
      rdm_q   <= 1'b0;
      wrote_q <= 1'b0;
      oe_q    <= 1'b0;
      wstb_q  <= 1'b0;
      rreq_q  <= 1'b0;
      scmt_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      addr_q  <= addr_n;
      wdat_q  <= wdat_n;
      aok_q   <= aok_n;
      rdm_q   <= rdm_n;
      wrote_q <= wrote_n;
      oe_q    <= oe_n;
      wstb_q  <= wstb_n;
      rreq_q  <= rreq_n;
      scmt_q  <= scmt_n;
    end
  end

  assign sda_pull    = oe_q;
  assign wr_stb      = wstb_q;
  assign wr_addr     = addr_q;
  assign wr_data     = wdat_q;
  assign rd_req      = rreq_q;
  assign rd_addr     = addr_q;
  assign stop_commit = scmt_q;

  // R11: a busy storage controller silences the engine on the next cycle
  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> (!sda_pull && !wr_stb && !rd_req));

  // R6: no strobe can follow a data byte seen with write-protect low
  p_wp_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(wp_n));

  // R5: strobes only target implemented, non-reserved addresses
  p_rsv_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr != RSV_B && wr_addr <= TOP_B));

  // R9: the stop indication is a single-cycle pulse
  p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_commit |=> !stop_commit);

  // R7: a read request is a single-cycle pulse and never coincides with a write
  p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (!wr_stb && $past(!rd_req)));

endmodule

// File: rtl/i2cs_reg_engine.sv
module i2cs_reg_engine #(
  parameter logic [6:0] DEV_ID      = 7'b0101000,
  parameter int         REG_TOP     = 2,
  parameter int         RSV_ADDR    = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_n,
  input  logic       nv_busy,
  output logic       sda_pull,
  output logic       reg_wr_stb,
  output logic [7:0] reg_wr_addr,
  output logic [7:0] reg_wr_data,
  output logic       reg_rd_req,
  output logic [7:0] reg_rd_addr,
  input  logic [7:0] reg_rd_data,
  output logic       stop_commit
);

  // reset asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [1:0] lvl, rise, fall;
  logic       bus_start, bus_stop;

  i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw   ({sda_i, scl_i}),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  i2cs_cond u_cond (
    .scl_lvl   (lvl[0]),
    .sda_rise  (rise[1]),
    .sda_fall  (fall[1]),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2cs_ctrl #(.DEV_ID(DEV_ID), .REG_TOP(REG_TOP), .RSV_ADDR(RSV_ADDR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .scl_rise    (rise[0]),
    .scl_fall    (fall[0]),
    .sda_lvl     (lvl[1]),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .wp_n        (wp_n),
    .nv_busy     (nv_busy),
    .rd_data     (reg_rd_data),
    .sda_pull    (sda_pull),
    .wr_stb      (reg_wr_stb),
    .wr_addr     (reg_wr_addr),
    .wr_data     (reg_wr_data),
    .rd_req      (reg_rd_req),
    .rd_addr     (reg_rd_addr),
    .stop_commit (stop_commit)
  );

  // R2: the pull enable only switches on while the synchronised clock is low
  p_pull_on_low_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sda_pull) |-> !$past(lvl[0]));

  // R10: a bus condition never arrives together with a write strobe
  p_cond_no_stb_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_start || bus_stop) |=> !reg_wr_stb);

endmodule

// File: tb/i2cs_reg_engine_test.sv
`timescale 1ns/1ps
module i2cs_reg_engine_test;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp_n = 1'b1;
  logic nv_busy = 1'b0;
  logic sda_pull, wr_stb, rd_req, stop_commit;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_bus;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2cs_reg_engine uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wp_n(wp_n), .nv_busy(nv_busy), .sda_pull(sda_pull),
    .reg_wr_stb(wr_stb), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_req(rd_req), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .stop_commit(stop_commit)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int fall_cyc = 0, lsb_fall = 0;
  int wr_cnt = 0, rd_cnt = 0, stop_cnt = 0, stb_cyc = 0;
  logic [7:0] last_wa = '0, last_wd = '0, last_ra = '0;
  logic [7:0] regs [3];

  assign rd_data = (rd_addr <= 8'd2) ? regs[rd_addr[1:0]] : 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      regs[0] <= 8'h00; regs[1] <= 8'h00; regs[2] <= 8'h00;
    end else begin
      if (wr_stb) begin
        wr_cnt <= wr_cnt + 1; last_wa <= wr_addr; last_wd <= wr_data; stb_cyc <= cyc;
        if (wr_addr <= 8'd2) regs[wr_addr[1:0]] <= wr_data;
      end
      if (rd_req) begin rd_cnt <= rd_cnt + 1; last_ra <= rd_addr; end
      if (stop_commit) stop_cnt <= stop_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask

  task automatic clk_bit(input logic b, output logic ln);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    ln = sda_bus; wait_q();
    scl_m = 1'b0; fall_cyc = cyc; wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic ln;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], ln);
    lsb_fall = fall_cyc;
    clk_bit(1'b1, ln);
    ack = !ln;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic ln;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], ln);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic ln;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, ln); b[i] = ln; end
    clk_bit(!mack, ln);
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1", "pull after reset", sda_pull, 0);
    chk(wr_cnt == 0 && rd_cnt == 0 && stop_cnt == 0, "R1", "pulses after reset", wr_cnt + rd_cnt + stop_cnt, 0);
  endtask

  task automatic t_write0();
    logic a; int w0 = wr_cnt, s0 = stop_cnt;
    bus_start();
    send_byte(8'h50, a); chk(a, "R2", "id write ack", a, 1);
    send_byte(8'h00, a); chk(a, "R3", "addr 0 ack", a, 1);
    send_byte(8'hA5, a); chk(a, "R4", "data ack", a, 1);
    chk(wr_cnt == w0 + 1, "R4", "strobe count", wr_cnt, w0 + 1);
    chk(last_wa == 8'h00 && last_wd == 8'hA5, "R4", "addr/data", {last_wa, last_wd}, 16'h00A5);
    chk(stb_cyc - lsb_fall == 3, "R4", "strobe latency", stb_cyc - lsb_fall, 3);
    bus_stop(); wait_q();
    chk(stop_cnt == s0 + 1, "R9", "stop indication after write", stop_cnt, s0 + 1);
  endtask

  task automatic t_write2_extra();
    logic a; int w0 = wr_cnt;
    bus_start();
    send_byte(8'h50, a); send_byte(8'h02, a);
    send_byte(8'h3C, a); chk(a, "R4", "addr2 data ack", a, 1);
    send_byte(8'h77, a); chk(!a, "R12", "second data byte nack", a, 0);
    chk(wr_cnt == w0 + 1 && last_wd == 8'h3C && last_wa == 8'h02, "R12", "only first byte strobed", last_wd, 8'h3C);
    bus_stop(); wait_q();
  endtask

  task automatic t_reserved();
    logic a; int w0 = wr_cnt, s0 = stop_cnt;
    bus_start();
    send_byte(8'h50, a); send_byte(8'h01, a); chk(a, "R3", "addr 1 ack", a, 1);
    send_byte(8'h99, a); chk(a, "R5", "reserved data ack", a, 1);
    chk(wr_cnt == w0, "R5", "no strobe for reserved", wr_cnt, w0);
    bus_stop(); wait_q();
    chk(stop_cnt == s0, "R9", "no stop indication without strobe", stop_cnt, s0);
  endtask

  task automatic t_bad_id();
    logic a; int w0 = wr_cnt;
    bus_start();
    send_byte(8'h52, a); chk(!a, "R2", "wrong id nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R2", "byte after wrong id ignored", a, 0);
    bus_stop(); wait_q();
    chk(wr_cnt == w0, "R2", "no strobe after wrong id", wr_cnt, w0);
  endtask

  task automatic t_bad_addr();
    logic a; int w0 = wr_cnt;
    bus_start();
    send_byte(8'h50, a); send_byte(8'h03, a); chk(!a, "R3", "addr 3 nack", a, 0);
    send_byte(8'h44, a); chk(!a, "R3", "data after bad addr nack", a, 0);
    bus_stop(); wait_q();
    chk(wr_cnt == w0, "R3", "no strobe after bad addr", wr_cnt, w0);
  endtask

  task automatic t_wp();
    logic a; int w0 = wr_cnt;
    wp_n = 1'b0;
    bus_start();
    send_byte(8'h50, a); send_byte(8'h00, a);
    send_byte(8'h12, a); chk(!a, "R6", "protected data nack", a, 0);
    send_byte(8'h13, a); chk(!a, "R6", "engine idle after protect", a, 0);
    bus_stop(); wait_q();
    wp_n = 1'b1;
    chk(wr_cnt == w0, "R6", "no strobe while protected", wr_cnt, w0);
  endtask

  task automatic t_read(input logic [7:0] ad, input logic [7:0] exp);
    logic a; logic [7:0] d; int r0 = rd_cnt, s0 = stop_cnt;
    bus_start();
    send_byte(8'h50, a); send_byte(ad, a);
    bus_start();
    send_byte(8'h51, a); chk(a, "R7", "read id ack", a, 1);
    chk(rd_cnt == r0 + 1 && last_ra == ad, "R7", "read request", last_ra, ad);
    recv_byte(1'b1, d);
    chk(d == exp, "R7", "read data", d, exp);
    bus_stop(); wait_q();
    chk(stop_cnt == s0, "R9", "no stop indication after read", stop_cnt, s0);
  endtask

  task automatic t_read_noaddr();
    logic a; int r0 = rd_cnt;
    bus_start();
    send_byte(8'h51, a); chk(!a, "R8", "read id without addr nack", a, 0);
    bus_stop(); wait_q();
    chk(rd_cnt == r0, "R8", "no read request", rd_cnt, r0);
  endtask

  task automatic t_abort();
    logic a; int w0 = wr_cnt;
    bus_start();
    send_byte(8'h50, a); send_bits(8'h00, 4);
    bus_start();
    send_byte(8'h50, a); chk(a, "R10", "id ack after mid-byte start", a, 1);
    send_byte(8'h02, a); send_byte(8'h11, a);
    bus_stop(); wait_q();
    chk(wr_cnt == w0 + 1 && last_wa == 8'h02 && last_wd == 8'h11, "R10", "write after resync", last_wd, 8'h11);
    bus_start(); send_bits(8'h50, 3); bus_stop(); wait_q();
    chk(wr_cnt == w0 + 1, "R10", "no strobe from aborted byte", wr_cnt, w0 + 1);
    bus_start(); send_byte(8'h50, a); chk(a, "R10", "id ack after mid-byte stop", a, 1);
    bus_stop(); wait_q();
  endtask

  task automatic t_busy();
    logic a; int w0 = wr_cnt;
    nv_busy = 1'b1; wait_q();
    bus_start();
    send_byte(8'h50, a); chk(!a, "R11", "id ignored while busy", a, 0);
    send_byte(8'h00, a); send_byte(8'h66, a);
    chk(!a && wr_cnt == w0, "R11", "no strobe while busy", wr_cnt, w0);
    bus_stop(); wait_q();
    bus_start();
    send_byte(8'h50, a);
    nv_busy = 1'b1;
    send_byte(8'h00, a); chk(!a, "R11", "busy mid transfer nack", a, 0);
    bus_stop(); wait_q();
    nv_busy = 1'b0; wait_q();
    bus_start();
    send_byte(8'h50, a); send_byte(8'h00, a); send_byte(8'h5A, a);
    bus_stop(); wait_q();
    chk(wr_cnt == w0 + 1 && last_wd == 8'h5A, "R11", "write after busy clears", last_wd, 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write0();
    t_write2_extra();
    t_reserved();
    t_bad_id();
    t_bad_addr();
    t_wp();
    t_read(8'h00, 8'hA5);
    t_read(8'h02, 8'h3C);
    t_read_noaddr();
    t_abort();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule